// File: doc/BRIEF.md
# PLL Power Sequencing Controller

This block steps a PLL domain through a safe power-up and power-down order. A power-up request walks the domain from fully off to running: the supply switch closes first, the isolation clamp opens after a short wait, the loop enable bits and the optional tuner enable come on after a second short wait, and the active-low PLL reset is released only after a long settling interval. A power-down request undoes these steps in mirror order, one step per clock, with no waits.

Two configuration straps say whether this domain has a tuner and whether it has a reset line. A step whose feature is absent leaves its output low. Wait lengths are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter. A request that arrives while a sequence is running is remembered and acted on once that sequence has finished. A request for the state the domain is already in has no effect. The `prepared` status output mirrors bit 0 of the enable bits.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, pwrOn=0, isoEn=1, pllEn=all zeros, tunerEn=0, pllRstN=0 and prepared=0.
- R2: With the domain off, an upReq sampled at a clock edge sets pwrOn at that edge. isoEn goes low exactly CYC_PER_US*PWR_WAIT_US cycles later.
- R3: Every pllEn bit goes to 1 exactly CYC_PER_US*PWR_WAIT_US cycles after isoEn goes low.
- R4: tunerEn goes high on the same edge as pllEn only when hasTuner=1. Otherwise it stays 0.
- R5: When hasRstBar=1, pllRstN goes high exactly CYC_PER_US*SETTLE_US cycles after pllEn is set. When hasRstBar=0 it stays 0.
- R6: With the domain fully up, a downReq sampled at edge b causes these changes on consecutive edges: pllRstN low at b, tunerEn low at b+1, all pllEn bits low at b+2, isoEn high at b+3, pwrOn low at b+4.
- R7: prepared always equals pllEn bit 0.
- R8: A request sampled while a sequence is in progress is held. A held downReq starts teardown one edge after the bring-up completes. A held upReq starts bring-up one edge after teardown completes.
- R9: upReq while fully up, and downReq while fully off, change no output and are not remembered.
- R10: isoEn is low only while pwrOn is high. pllEn is non-zero only while isoEn is low. tunerEn and pllRstN are high only while pllEn bit 0 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upReq | input | 1 | Request to power the domain up |
| downReq | input | 1 | Request to power the domain down |
| hasTuner | input | 1 | Strap: domain has a tuner enable |
| hasRstBar | input | 1 | Strap: domain has an active-low PLL reset |
| pwrOn | output | 1 | Power switch control, high = on |
| isoEn | output | 1 | Isolation clamp, high = isolated |
| pllEn | output | EN_W | PLL enable bits |
| tunerEn | output | 1 | Tuner enable |
| pllRstN | output | 1 | PLL reset, low = held in reset |
| prepared | output | 1 | Status: enable bit 0 read back |

## Verification
The bench builds the block with CYC_PER_US=3, PWR_WAIT_US=1, SETTLE_US=20 and EN_W=2. With these values each short wait is 3 cycles and the settle wait is 60 cycles. Every edge of both sequences, and the cycle just before each timed release, can then be sampled exactly within a short run. The two-bit enable makes sure that all enable bits are driven, not only the one that prepared reads back. The bench covers all four strap combinations, and it places held requests partway through bring-up and through teardown.

// File: rtl/pll_pwr_seq_pkg.sv
package pll_pwr_seq_pkg;

  // One-cycle commands from the sequencer to the output/timer datapath
  typedef struct packed {
    logic setPwr;
    logic clrPwr;
    logic clrIso;
    logic setIso;
    logic setEn;
    logic clrEn;
    logic setTun;
    logic clrTun;
    logic relRst;
    logic clrRst;
    logic loadShort;
    logic loadLong;
  } seq_strobe_t;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PWR_WAIT,
    ST_ISO_WAIT,
    ST_SETTLE,
    ST_ON,
    ST_DN_TUN,
    ST_DN_EN,
    ST_DN_ISO,
    ST_DN_PWR
  } seq_state_t;

endpackage

// File: rtl/pll_pwr_seq_ctrl.sv
module pll_pwr_seq_ctrl
  import pll_pwr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        upReq,
  input  logic        downReq,
  input  logic        hasTuner,
  input  logic        hasRstBar,
  input  logic        timerDone,
  output seq_strobe_t stb
);

  seq_state_t state, stateNxt;
  logic pendUp, pendDown;
  logic goUp, goDown, atRest;

  assign atRest = (state == ST_OFF) || (state == ST_ON);
  assign goUp   = upReq | pendUp;
  assign goDown = downReq | pendDown;

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_OFF: if (goUp) begin
        stb.setPwr    = 1'b1;
        stb.loadShort = 1'b1;
        stateNxt      = ST_PWR_WAIT;
      end
      ST_PWR_WAIT: if (timerDone) begin
        stb.clrIso    = 1'b1;
        stb.loadShort = 1'b1;
        stateNxt      = ST_ISO_WAIT;
      end
      ST_ISO_WAIT: if (timerDone) begin
        stb.setEn    = 1'b1;
        stb.setTun   = hasTuner;
        stb.loadLong = 1'b1;
        stateNxt     = ST_SETTLE;
      end
      ST_SETTLE: if (timerDone) begin
        stb.relRst = hasRstBar;
        stateNxt   = ST_ON;
      end
      ST_ON: if (goDown) begin
        stb.clrRst = 1'b1;
        stateNxt   = ST_DN_TUN;
      end
      ST_DN_TUN: begin
        stb.clrTun = 1'b1;
        stateNxt   = ST_DN_EN;
      end
      ST_DN_EN: begin
        stb.clrEn = 1'b1;
        stateNxt  = ST_DN_ISO;
      end
      ST_DN_ISO: begin
        stb.setIso = 1'b1;
        stateNxt   = ST_DN_PWR;
      end
      ST_DN_PWR: begin
        stb.clrPwr = 1'b1;
        stateNxt   = ST_OFF;
      end
      default: stateNxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      pendUp   <= 1'b0;
      pendDown <= 1'b0;
    end else begin
      state <= stateNxt;
      // Requests are held only while a sequence is running
      pendUp   <= atRest ? 1'b0 : (pendUp | upReq);
      pendDown <= atRest ? 1'b0 : (pendDown | downReq);
    end
  end

endmodule

// File: rtl/pll_pwr_seq_dp.sv
module pll_pwr_seq_dp
  import pll_pwr_seq_pkg::*;
#(
  parameter int EN_W      = 2,
  parameter int SHORT_CYC = 100,
  parameter int LONG_CYC  = 2000
) (
  input  logic            clk,
  input  logic            rstN,
  input  seq_strobe_t     stb,
  output logic            timerDone,
  output logic            pwrOn,
  output logic            isoEn,
  output logic [EN_W-1:0] pllEn,
  output logic            tunerEn,
  output logic            pllRstN
);

  localparam int MAX_CYC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);

  logic [TW-1:0] timer;

  assign timerDone = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (stb.loadShort) begin
      timer <= TW'(SHORT_CYC - 1);
    end else if (stb.loadLong) begin
      timer <= TW'(LONG_CYC - 1);
    end else if (!timerDone) begin
      timer <= timer - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOn   <= 1'b0;
      isoEn   <= 1'b1;
      pllEn   <= '0;
      tunerEn <= 1'b0;
      pllRstN <= 1'b0;
    end else begin
      if (stb.setPwr)      pwrOn <= 1'b1;
      else if (stb.clrPwr) pwrOn <= 1'b0;
      if (stb.clrIso)      isoEn <= 1'b0;
      else if (stb.setIso) isoEn <= 1'b1;
      if (stb.setEn)       pllEn <= '1;
      else if (stb.clrEn)  pllEn <= '0;
      if (stb.setTun)      tunerEn <= 1'b1;
      else if (stb.clrTun) tunerEn <= 1'b0;
      if (stb.relRst)      pllRstN <= 1'b1;
      else if (stb.clrRst) pllRstN <= 1'b0;
    end
  end

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_pwr_seq_pkg::*;
#(
  parameter int CYC_PER_US  = 100,
  parameter int PWR_WAIT_US = 1,
  parameter int SETTLE_US   = 20,
  parameter int EN_W        = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            upReq,
  input  logic            downReq,
  input  logic            hasTuner,
  input  logic            hasRstBar,
  output logic            pwrOn,
  output logic            isoEn,
  output logic [EN_W-1:0] pllEn,
  output logic            tunerEn,
  output logic            pllRstN,
  output logic            prepared
);

  localparam int SHORT_CYC = CYC_PER_US * PWR_WAIT_US;
  localparam int LONG_CYC  = CYC_PER_US * SETTLE_US;

  seq_strobe_t stb;
  logic        timerDone;

  pll_pwr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .upReq     (upReq),
    .downReq   (downReq),
    .hasTuner  (hasTuner),
    .hasRstBar (hasRstBar),
    .timerDone (timerDone),
    .stb       (stb)
  );

  pll_pwr_seq_dp #(
    .EN_W      (EN_W),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .timerDone (timerDone),
    .pwrOn     (pwrOn),
    .isoEn     (isoEn),
    .pllEn     (pllEn),
    .tunerEn   (tunerEn),
    .pllRstN   (pllRstN)
  );

  // Status reads back the lowest enable bit (R7)
  assign prepared = pllEn[0];

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
  parameter int EN_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            hasTuner,
  input logic            pwrOn,
  input logic            isoEn,
  input logic [EN_W-1:0] pllEn,
  input logic            tunerEn,
  input logic            pllRstN
);

  assert_iso_needs_pwr_R10: assert property (@(posedge clk) disable iff (!rstN)
    !isoEn |-> pwrOn);

  assert_en_needs_iso_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|pllEn) |-> !isoEn);

  assert_tuner_needs_en_R10: assert property (@(posedge clk) disable iff (!rstN)
    tunerEn |-> pllEn[0]);

  assert_rst_needs_en_R10: assert property (@(posedge clk) disable iff (!rstN)
    pllRstN |-> pllEn[0]);

  assert_tuner_strap_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tunerEn) |-> hasTuner);

  assert_pwr_drop_isolated_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrOn) |-> $past(isoEn));

  assert_en_drop_after_tuner_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllEn[0]) |-> (!tunerEn && !pllRstN));

endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(.EN_W(EN_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hasTuner (hasTuner),
  .pwrOn    (pwrOn),
  .isoEn    (isoEn),
  .pllEn    (pllEn),
  .tunerEn  (tunerEn),
  .pllRstN  (pllRstN)
);

// File: tb/pll_pwr_seq_test.sv
module pll_pwr_seq_test;

  localparam int CPU = 3;
  localparam int PWR_US = 1;
  localparam int SETTLE_US = 20;
  localparam int EN_W = 2;
  localparam int S = CPU * PWR_US;
  localparam int L = CPU * SETTLE_US;
  localparam int VW = EN_W + 4;

  logic clk = 1'b0, rstN = 1'b0, upReq = 1'b0, downReq = 1'b0;
  logic hasTuner = 1'b0, hasRstBar = 1'b0;
  logic pwrOn, isoEn, tunerEn, pllRstN, prepared;
  logic [EN_W-1:0] pllEn;

  pll_pwr_seq #(.CYC_PER_US(CPU), .PWR_WAIT_US(PWR_US), .SETTLE_US(SETTLE_US), .EN_W(EN_W)) uut (
    .clk(clk), .rstN(rstN), .upReq(upReq), .downReq(downReq),
    .hasTuner(hasTuner), .hasRstBar(hasRstBar),
    .pwrOn(pwrOn), .isoEn(isoEn), .pllEn(pllEn), .tunerEn(tunerEn),
    .pllRstN(pllRstN), .prepared(prepared)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    logic [VW-1:0] vec;
    string       tag;
  } item_t;

  item_t q[$];
  int nChecks = 0, nFails = 0;

  // Reference model of the outputs, stepped by the driver
  logic mPwr = 1'b0, mIso = 1'b1, mTun = 1'b0, mRst = 1'b0;
  logic [EN_W-1:0] mEn = '0;

  task automatic push(input int at, input string tag);
    item_t it;
    it.at  = at;
    it.vec = {mPwr, mIso, mEn, mTun, mRst};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expectUp(input int b, input logic t, input logic r);
    mPwr = 1'b1; push(b, "R2");
    push(b + S - 1, "R2");
    mIso = 1'b0; push(b + S, "R2");
    push(b + 2*S - 1, "R3");
    mEn = '1; mTun = t; push(b + 2*S, "R3 R4");
    push(b + 2*S + L - 1, "R5");
    mRst = r; push(b + 2*S + L, "R5");
  endtask

  task automatic expectDown(input int b);
    mRst = 1'b0; push(b,     "R6");
    mTun = 1'b0; push(b + 1, "R6");
    mEn  = '0;   push(b + 2, "R6");
    mIso = 1'b1; push(b + 3, "R6");
    mPwr = 1'b0; push(b + 4, "R6");
  endtask

  task automatic waitUntil(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic doUp(input logic t, input logic r);
    int c0;
    hasTuner = t; hasRstBar = r;
    c0 = cyc; upReq = 1'b1;
    expectUp(c0 + 1, t, r);
    @(negedge clk); upReq = 1'b0;
    waitUntil(c0 + 2*S + L + 3);
  endtask

  task automatic doDown();
    int c0;
    c0 = cyc; downReq = 1'b1;
    expectDown(c0 + 1);
    @(negedge clk); downReq = 1'b0;
    waitUntil(c0 + 8);
  endtask

  // Monitor: pops expected items when their cycle comes up
  always @(negedge clk) begin
    item_t it;
    logic [VW-1:0] got;
    while (q.size() > 0 && q[0].at <= cyc) begin
      it  = q.pop_front();
      got = {pwrOn, isoEn, pllEn, tunerEn, pllRstN};
      nChecks++;
      if (it.at != cyc || got !== it.vec) begin
        nFails++;
        $display("FAIL %s cycle %0d: actual %b expected %b (pwr,iso,en,tun,rst)",
                 it.tag, it.at, got, it.vec);
      end
      nChecks++;
      if (prepared !== pllEn[0]) begin
        nFails++;
        $display("FAIL R7 cycle %0d: actual prepared %b expected %b", cyc, prepared, pllEn[0]);
      end
    end
  end

  initial begin
    #(5000 * 10);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int c0;
    int b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    c0 = cyc; push(c0 + 1, "R1"); push(c0 + 2, "R1");
    waitUntil(c0 + 3);

    // Main sequences across strap combinations
    doUp(1'b1, 1'b1); doDown();
    doUp(1'b0, 1'b0); doDown();
    doUp(1'b1, 1'b0); doDown();
    doUp(1'b0, 1'b1); doDown();

    // R8: downReq during bring-up is held
    hasTuner = 1'b0; hasRstBar = 1'b1;
    c0 = cyc; upReq = 1'b1;
    expectUp(c0 + 1, 1'b0, 1'b1);
    b = c0 + 1 + 2*S + L;
    expectDown(b + 1);
    @(negedge clk); upReq = 1'b0;
    repeat (4) @(negedge clk);
    downReq = 1'b1;
    @(negedge clk); downReq = 1'b0;
    waitUntil(b + 8);

    // R8: upReq during teardown is held
    doUp(1'b1, 1'b0);
    c0 = cyc; downReq = 1'b1;
    b = c0 + 1;
    expectDown(b);
    expectUp(b + 5, 1'b1, 1'b0);
    @(negedge clk); downReq = 1'b0;
    @(negedge clk); upReq = 1'b1;
    @(negedge clk); upReq = 1'b0;
    waitUntil(b + 5 + 2*S + L + 2);
    doDown();

    // R9: downReq while off has no effect and is not kept
    c0 = cyc; push(c0 + 1, "R9"); push(c0 + 4, "R9");
    downReq = 1'b1;
    @(negedge clk); downReq = 1'b0;
    waitUntil(c0 + 5);
    doUp(1'b1, 1'b1);
    // R9: upReq while on has no effect; stays on (no stale downReq)
    c0 = cyc; push(c0 + 1, "R9"); push(c0 + 6, "R9");
    upReq = 1'b1;
    @(negedge clk); upReq = 1'b0;
    waitUntil(c0 + 7);
    doDown();

    waitUntil(cyc + 2);
    if (q.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule